// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host reach a wider internal register space through three directly addressed window words: a command word, a data word and a status word. The host writes the command word to start one internal access, a read or a write. It polls the ready bit in the status word until that access finishes, then collects read data from the data word. Only one internal access can be in flight at a time.

Two kinds of internal target sit behind the window. A small bank of fast core configuration registers answers in a few cycles. A management-bus range answers only after a much longer, parameterised delay. This project models that range with a small stub register file, and does not model the serial bus itself. Any other address is unmapped: it reads as zero, ignores writes and answers with the fast latency. A command that arrives while an access is still running is dropped, and it sets a sticky overrun flag that software clears explicitly.

Top module: `ind_reg_bridge`

## Requirements
- R1: Window decode on `hostAddr`: 0 is the command word, 1 the data word, 2 the status word and 3 reads as zero. The command word reads back the internal address of the last accepted command in bits [9:0] and its write flag in bit 15. The status word has ready in bit 0 and overrun in bit 1.
- R2: When ready is high, a command-word write with bit 15 clear starts a read of the internal address in bits [9:0]. When ready returns high, the data word holds that register's value.
- R3: When ready is high, a command-word write with bit 15 set writes the current data-word contents to the addressed register. The write takes effect when ready returns high.
- R4: After an accepted command, ready is low for exactly CORE_LAT cycles (default 4) for core and unmapped addresses, and for exactly MGMT_LAT cycles (default 64) for the management range 0x300–0x3FF. Ready never falls without a command.
- R5: A command-word write while ready is low is dropped. The command readback, the running access and the data are unaffected, and the overrun flag is set. This includes a write in the very cycle the running access completes.
- R6: Overrun stays set until the host writes the status word with bit 1 set. A status write with bit 1 clear leaves it set.
- R7: An unmapped address (0x008–0x2FF) reads as zero and ignores writes.
- R8: Data-word writes made while ready is low are ignored.
- R9: The management range holds four words selected by address bits [1:0], aliased across the whole range, separate from the core registers at 0x000–0x007.
- R10: After reset, ready is 1, overrun is 0, and the command word, the data word and all internal registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe for the window word selected by hostAddr |
| hostAddr | input | 2 | Window word select |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Window read data for hostAddr, combinational |

## Verification
The critical overlap is a new command landing in the same cycle that the running access completes. That edge both commits the old access and samples the new command. The bench times a command-word write to fall exactly on the fourth cycle of a core read. It then expects ready high, overrun set, the old command still in the readback and the old read result in the data word. A data-word write during a pending write is also checked to confirm that the committed value is the one loaded before the command.

// File: rtl/ind_reg_bridge_pkg.sv
package ind_reg_bridge_pkg;
  localparam int CMD_AW = 10;
  localparam int WIN_AW = 2;
  localparam logic [WIN_AW-1:0] WIN_CMD  = 2'd0;
  localparam logic [WIN_AW-1:0] WIN_DATA = 2'd1;
  localparam logic [WIN_AW-1:0] WIN_STAT = 2'd2;

  typedef enum logic [1:0] {TGT_NONE, TGT_CORE, TGT_MGMT} tgt_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic              dataLoad;
    logic              commit;
    logic              isWrite;
    tgt_e              tgt;
    logic [CMD_AW-1:0] addr;
  } seq_strobe_t;
endpackage

// File: rtl/ind_reg_bridge_ctrl.sv
module ind_reg_bridge_ctrl
  import ind_reg_bridge_pkg::*;
#(
  parameter int CORE_COUNT = 8,
  parameter logic [CMD_AW-1:0] MGMT_BASE = 10'h300,
  parameter int CORE_LAT = 4,
  parameter int MGMT_LAT = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic [WIN_AW-1:0] hostAddr,
  input  logic [CMD_AW-1:0] wrAddrField,
  input  logic              wrWeBit,
  input  logic              wrClrBit,
  output seq_strobe_t       strobe,
  output logic              busy,
  output logic              overrun
);
  localparam int CNT_W = $clog2(MGMT_LAT + 1);
  localparam logic [CMD_AW-1:0] CORE_LIM = CMD_AW'(CORE_COUNT);

  logic              cmdWr, statWr, dataWr;
  logic [CNT_W-1:0]  cnt, startCnt;
  logic [CMD_AW-1:0] cmdAddr;
  logic              cmdWe;
  tgt_e              cmdTgt, newTgt;

  assign cmdWr  = hostWr && (hostAddr == WIN_CMD);
  assign statWr = hostWr && (hostAddr == WIN_STAT);
  assign dataWr = hostWr && (hostAddr == WIN_DATA);

  always_comb begin
    if (wrAddrField < CORE_LIM)        newTgt = TGT_CORE;
    else if (wrAddrField >= MGMT_BASE) newTgt = TGT_MGMT;
    else                               newTgt = TGT_NONE;
    startCnt = (newTgt == TGT_MGMT) ? CNT_W'(MGMT_LAT - 1) : CNT_W'(CORE_LAT - 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      cnt     <= '0;
      cmdAddr <= '0;
      cmdWe   <= 1'b0;
      cmdTgt  <= TGT_NONE;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (cmdWr) begin
      busy    <= 1'b1;
      cnt     <= startCnt;
      cmdAddr <= wrAddrField;
      cmdWe   <= wrWeBit;
      cmdTgt  <= newTgt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   overrun <= 1'b0;
    else if (cmdWr && busy)      overrun <= 1'b1;
    else if (statWr && wrClrBit) overrun <= 1'b0;
  end

  always_comb begin
    strobe.dataLoad = dataWr && !busy;
    strobe.commit   = busy && (cnt == '0);
    strobe.isWrite  = cmdWe;
    strobe.tgt      = cmdTgt;
    strobe.addr     = cmdAddr;
  end
endmodule

// File: rtl/ind_reg_bridge_dp.sv
module ind_reg_bridge_dp
  import ind_reg_bridge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CORE_COUNT = 8,
  parameter int MGMT_COUNT = 4,
  parameter int WE_BIT = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WIN_AW-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  seq_strobe_t       strobe,
  input  logic              busy,
  input  logic              overrun,
  output logic [DATA_W-1:0] hostRdata
);
  localparam int CORE_IW = $clog2(CORE_COUNT);
  localparam int MGMT_IW = $clog2(MGMT_COUNT);

  logic [DATA_W-1:0]  dataReg;
  logic [DATA_W-1:0]  coreReg [CORE_COUNT];
  logic [DATA_W-1:0]  mgmtReg [MGMT_COUNT];
  logic [CORE_IW-1:0] coreIdx;
  logic [MGMT_IW-1:0] mgmtIdx;
  logic               wrCommit;

  assign coreIdx  = strobe.addr[CORE_IW-1:0];
  assign mgmtIdx  = strobe.addr[MGMT_IW-1:0];
  assign wrCommit = strobe.commit && strobe.isWrite;

  for (genvar i = 0; i < CORE_COUNT; i++) begin : g_core
    always_ff @(posedge clk) begin
      if (!rstN) coreReg[i] <= '0;
      else if (wrCommit && strobe.tgt == TGT_CORE && coreIdx == CORE_IW'(i))
        coreReg[i] <= dataReg;
    end
  end

  for (genvar j = 0; j < MGMT_COUNT; j++) begin : g_mgmt
    always_ff @(posedge clk) begin
      if (!rstN) mgmtReg[j] <= '0;
      else if (wrCommit && strobe.tgt == TGT_MGMT && mgmtIdx == MGMT_IW'(j))
        mgmtReg[j] <= dataReg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) dataReg <= '0;
    else if (strobe.dataLoad) dataReg <= hostWdata;
    else if (strobe.commit && !strobe.isWrite) begin
      case (strobe.tgt)
        TGT_CORE: dataReg <= coreReg[coreIdx];
        TGT_MGMT: dataReg <= mgmtReg[mgmtIdx];
        default:  dataReg <= '0;
      endcase
    end
  end

  always_comb begin
    hostRdata = '0;
    case (hostAddr)
      WIN_CMD: begin
        hostRdata[CMD_AW-1:0] = strobe.addr;
        hostRdata[WE_BIT]     = strobe.isWrite;
      end
      WIN_DATA: hostRdata = dataReg;
      WIN_STAT: begin
        hostRdata[0] = ~busy;
        hostRdata[1] = overrun;
      end
      default: hostRdata = '0;
    endcase
  end
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import ind_reg_bridge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CORE_COUNT = 8,
  parameter int MGMT_COUNT = 4,
  parameter logic [CMD_AW-1:0] MGMT_BASE = 10'h300,
  parameter int CORE_LAT = 4,
  parameter int MGMT_LAT = 64,
  parameter int WE_BIT = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic [1:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata
);
  seq_strobe_t strobe;
  logic        seqBusy;
  logic        seqOverrun;

  ind_reg_bridge_ctrl #(
    .CORE_COUNT(CORE_COUNT), .MGMT_BASE(MGMT_BASE),
    .CORE_LAT(CORE_LAT), .MGMT_LAT(MGMT_LAT)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostAddr(hostAddr),
    .wrAddrField(hostWdata[CMD_AW-1:0]), .wrWeBit(hostWdata[WE_BIT]),
    .wrClrBit(hostWdata[1]), .strobe(strobe), .busy(seqBusy),
    .overrun(seqOverrun)
  );

  ind_reg_bridge_dp #(
    .DATA_W(DATA_W), .CORE_COUNT(CORE_COUNT),
    .MGMT_COUNT(MGMT_COUNT), .WE_BIT(WE_BIT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .strobe(strobe), .busy(seqBusy), .overrun(seqOverrun),
    .hostRdata(hostRdata)
  );
endmodule

// File: rtl/ind_reg_bridge_chk.sv
module ind_reg_bridge_chk #(
  parameter int DATA_W = 32,
  parameter int MGMT_LAT = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWr,
  input logic [1:0]        hostAddr,
  input logic              clrBit,
  input logic [DATA_W-1:0] hostRdata,
  input logic              busy,
  input logic              overrun,
  input logic              commit
);
  localparam int RW = $clog2(MGMT_LAT + 1) + 1;
  logic [RW-1:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == 2'd0 && !busy) |=> busy);

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !(hostWr && hostAddr == 2'd0)) |=> !busy);

  p_latency_cap_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun < RW'(MGMT_LAT)));

  p_commit_ends_r4: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> !busy);

  p_overrun_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == 2'd0 && busy) |=> overrun);

  p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !(hostWr && hostAddr == 2'd2 && clrBit)) |=> overrun);

  p_data_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !commit && hostAddr == 2'd1) |=> (hostAddr != 2'd1 || $stable(hostRdata)));
endmodule

bind ind_reg_bridge ind_reg_bridge_chk #(.DATA_W(DATA_W), .MGMT_LAT(MGMT_LAT)) chk_i (
  .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostAddr(hostAddr),
  .clrBit(hostWdata[1]), .hostRdata(hostRdata), .busy(seqBusy),
  .overrun(seqOverrun), .commit(strobe.commit)
);

// File: tb/ind_reg_bridge_tb_top.sv
module ind_reg_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWr = 1'b0;
  logic [1:0]  hostAddr = 2'd2;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  int errCnt = 0;
  int chkCnt = 0;

  always #5 clk = ~clk;

  ind_reg_bridge dut_i (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWr = 1'b0; hostAddr = 2'd2;
  endtask

  task automatic hrd(input logic [1:0] a, output logic [31:0] v);
    hostAddr = a;
    #1;
    v = hostRdata;
  endtask

  task automatic waitReady(output int n);
    logic [31:0] s;
    n = 0;
    hrd(2'd2, s);
    while (s[0] == 1'b0 && n < 1000) begin
      n++;
      @(negedge clk);
      hrd(2'd2, s);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    hrd(2'd2, v); check("R10 status after reset", v, 32'h1);
    hrd(2'd1, v); check("R10 data after reset", v, 32'h0);
    hrd(2'd0, v); check("R10 command after reset", v, 32'h0);
    hrd(2'd3, v); check("R1 unused window word", v, 32'h0);
  endtask

  task automatic t_core_rw();
    logic [31:0] v; int n;
    hwr(2'd1, 32'hA5A50003);
    hwr(2'd0, 32'h0000_8003);
    waitReady(n); check("R4 core write latency", n, 4);
    hrd(2'd0, v); check("R1 command readback write", v, 32'h0000_8003);
    hwr(2'd1, 32'h0);
    hwr(2'd0, 32'h0000_0003);
    waitReady(n); check("R4 core read latency", n, 4);
    hrd(2'd1, v); check("R2 R3 core read result", v, 32'hA5A50003);
    hrd(2'd0, v); check("R1 command readback read", v, 32'h0000_0003);
  endtask

  task automatic t_mgmt();
    logic [31:0] v; int n;
    hwr(2'd1, 32'hC0DE0301);
    hwr(2'd0, 32'h0000_8301);
    waitReady(n); check("R4 mgmt write latency", n, 64);
    hwr(2'd0, 32'h0000_03F1);
    waitReady(n); check("R4 mgmt read latency", n, 64);
    hrd(2'd1, v); check("R9 mgmt alias readback", v, 32'hC0DE0301);
    hwr(2'd0, 32'h0000_0001);
    waitReady(n);
    hrd(2'd1, v); check("R9 core space separate", v, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v; int n;
    hwr(2'd1, 32'h12345678);
    hwr(2'd0, 32'h0000_8050);
    waitReady(n); check("R7 unmapped write latency", n, 4);
    hwr(2'd0, 32'h0000_0050);
    waitReady(n); check("R7 unmapped read latency", n, 4);
    hrd(2'd1, v); check("R7 unmapped reads zero", v, 32'h0);
  endtask

  task automatic t_overrun_busy();
    logic [31:0] v; int n;
    hwr(2'd1, 32'h11112222);
    hwr(2'd0, 32'h0000_8302);
    hwr(2'd0, 32'h0000_0005);
    hrd(2'd2, v); check("R5 overrun set while busy", v, 32'h2);
    waitReady(n);
    hrd(2'd0, v); check("R5 dropped command not taken", v, 32'h0000_8302);
    hwr(2'd0, 32'h0000_0306);
    waitReady(n);
    hrd(2'd1, v); check("R5 running write unaffected", v, 32'h11112222);
    hrd(2'd2, v); check("R6 overrun sticky", v, 32'h3);
    hwr(2'd2, 32'h0);
    hrd(2'd2, v); check("R6 status write without clear", v, 32'h3);
    hwr(2'd2, 32'h2);
    hrd(2'd2, v); check("R6 overrun cleared", v, 32'h1);
  endtask

  task automatic t_data_busy();
    logic [31:0] v; int n;
    hwr(2'd1, 32'hAAAA0000);
    hwr(2'd0, 32'h0000_8006);
    hwr(2'd1, 32'h55555555);
    hrd(2'd1, v); check("R8 data write ignored while busy", v, 32'hAAAA0000);
    waitReady(n);
    hwr(2'd0, 32'h0000_0006);
    waitReady(n);
    hrd(2'd1, v); check("R8 committed value", v, 32'hAAAA0000);
  endtask

  task automatic t_collision();
    logic [31:0] v; int n;
    hwr(2'd0, 32'h0000_0003);
    @(negedge clk);
    @(negedge clk);
    hwr(2'd0, 32'h0000_8007);
    hrd(2'd2, v); check("R5 command on completion cycle", v, 32'h3);
    hrd(2'd0, v); check("R5 completion command readback", v, 32'h0000_0003);
    hrd(2'd1, v); check("R5 completion read data", v, 32'hA5A50003);
    @(negedge clk);
    hrd(2'd2, v); check("R5 no second access started", v, 32'h3);
    hwr(2'd2, 32'h2);
    waitReady(n);
  endtask

  initial begin
    #1_000_000;
    errCnt++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_core_rw();
    t_mgmt();
    t_unmapped();
    t_overrun_busy();
    t_data_busy();
    t_collision();
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule